// File: doc/BRIEF.md
# Indexed Address Postbyte Engine

This block turns the postbyte of an indexed-mode instruction into a 16-bit effective address. A start strobe presents the postbyte together with a snapshot of the four index registers, the two 8-bit accumulators and the program counter, which at that point addresses the first byte after the postbyte. The block decodes the postbyte. It reads up to two offset bytes through a byte-wide memory read port and forms the address. It reports a register write-back for the auto-update modes and, when the indirect bit is set, fetches a pointer word to use as the final address.

The results come back with a one-cycle done pulse: the effective address, the advanced program counter and the extra cycle cost of the addressing mode. They stay valid until the next start. The memory port issues one request at a time and waits for a valid response. Opcode decode, the accumulators and the register file itself belong to the surrounding core.

Top module: `idx_postbyte_ea`

## Requirements
- R1: Postbyte bits 6:5 pick the base register: 0 = reg_x, 1 = reg_y, 2 = reg_u, 3 = reg_s, and idx_sel reports that choice.
- R2: With bit 7 clear, bits 4:0 are a signed offset (-16..+15) added to the base. The cost is 1, no bytes are read and pc_next equals pc_in.
- R3: With bit 7 set, low nibble 0 or 1 post-increments by 1 or 2. The address is the base before the update. Exactly one idx_we pulse carries base+1 or base+2, and the cost is 2 or 3.
- R4: Low nibble 2 or 3 pre-decrements by 1 or 2. Both the address and the single write-back value are base-1 or base-2, the cost is 2 or 3, and all arithmetic wraps modulo 2^16.
- R5: Low nibble 4 adds nothing (cost 0). Nibble 5 adds signed acc_b and nibble 6 adds signed acc_a (cost 1). Nibble B adds the 16-bit value {acc_a, acc_b} (cost 4).
- R6: Nibble 8 reads one signed offset byte at pc_in (cost 1). Nibble 9 reads a 16-bit offset, high byte at pc_in and low byte at pc_in+1 (cost 4). pc_next is pc_in plus the bytes read.
- R7: Nibbles C and D add an 8-bit signed or a 16-bit offset to pc_next rather than to a register. The costs are 1 and 5.
- R8: Nibble F reads a 16-bit absolute address (high byte first, cost 3), and pc_next is pc_in+2.
- R9: Nibbles 7, A and E give address 0x0000 with cost 0. They read no offset bytes and raise no idx_we.
- R10: With bits 7 and 4 both set, the computed address is a pointer. The word read there (high byte at the pointer, low byte at pointer+1 modulo 2^16) becomes ea, and the cost grows by 3.
- R11: done is a one-cycle pulse. It arrives 2 + 2*(offset bytes) + 4*(indirect) clocks after the edge that samples start. At most one memory request is outstanding.
- R12: After reset, done, idx_we and mem_req are low and ea, pc_next and cost are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin decoding; sampled only when idle |
| postbyte | input | 8 | Indexed-mode postbyte |
| reg_x | input | 16 | Index register 0 |
| reg_y | input | 16 | Index register 1 |
| reg_u | input | 16 | Index register 2 |
| reg_s | input | 16 | Index register 3 |
| acc_a | input | 8 | Accumulator A (high half of D) |
| acc_b | input | 8 | Accumulator B (low half of D) |
| pc_in | input | 16 | Address of the byte after the postbyte |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 16 | Byte read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data |
| ea | output | 16 | Effective address |
| pc_next | output | 16 | Program counter after offset bytes |
| cost | output | 4 | Extra cycles charged for the mode |
| idx_we | output | 1 | Index register write-back strobe |
| idx_sel | output | 2 | Register written back |
| idx_wdata | output | 16 | Write-back value |
| done | output | 1 | Results valid pulse |

## Verification
Every result appears together with done. For a mode with no memory traffic, done arrives 2 clocks after start is sampled. Each offset byte adds 2 clocks, one for the request and one for the response from the one-cycle memory model, and an indirect fetch adds 4. The bench counts falling edges from the sampling edge until done, compares that count with the formula for every case, and reads ea, pc_next and cost in that same half-cycle. idx_we is watched on every falling edge between start and done, so its pulse count and data are checked as well.

// File: rtl/idx_pb_pkg.sv
package idx_pb_pkg;

   typedef enum logic [3:0] {
      K_SHORT, K_INC1, K_INC2, K_DEC1, K_DEC2, K_ZERO, K_ACCB, K_ACCA,
      K_OFS8, K_OFS16, K_ACCD, K_PC8, K_PC16, K_ABS, K_ILL
   } ea_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_REQ, ST_WAIT, ST_CALC, ST_FIN
   } seq_state_e;

   // Number of offset bytes following a postbyte.
   function automatic logic [1:0] ofs_bytes(input logic [7:0] pb);
      logic [1:0] n;
      n = 2'd0;
      if (pb[7]) begin
         case (pb[3:0])
            4'h8, 4'hC:        n = 2'd1;
            4'h9, 4'hD, 4'hF:  n = 2'd2;
            default:           n = 2'd0;
         endcase
      end
      return n;
   endfunction

endpackage

// File: rtl/idx_pb_decode.sv
module idx_pb_decode
   import idx_pb_pkg::*;
#(
   parameter int COST_W = 4
) (
   input  logic [7:0]        pb,
   output ea_kind_e          kind,
   output logic              indirect,
   output logic              auto_upd,
   output logic [COST_W-1:0] cost
);

   localparam int IND_COST = 3;

   generate
      if (COST_W < 4) begin : g_bad_cost
         $error("COST_W must hold a cost of 8");
      end
   endgenerate

   logic [COST_W-1:0] base_cost;

   always_comb begin
      kind      = K_ILL;
      base_cost = '0;
      if (!pb[7]) begin
         kind      = K_SHORT;
         base_cost = COST_W'(1);
      end else begin
         case (pb[3:0])
            4'h0: begin kind = K_INC1;  base_cost = COST_W'(2); end
            4'h1: begin kind = K_INC2;  base_cost = COST_W'(3); end
            4'h2: begin kind = K_DEC1;  base_cost = COST_W'(2); end
            4'h3: begin kind = K_DEC2;  base_cost = COST_W'(3); end
            4'h4: begin kind = K_ZERO;  base_cost = COST_W'(0); end
            4'h5: begin kind = K_ACCB;  base_cost = COST_W'(1); end
            4'h6: begin kind = K_ACCA;  base_cost = COST_W'(1); end
            4'h8: begin kind = K_OFS8;  base_cost = COST_W'(1); end
            4'h9: begin kind = K_OFS16; base_cost = COST_W'(4); end
            4'hB: begin kind = K_ACCD;  base_cost = COST_W'(4); end
            4'hC: begin kind = K_PC8;   base_cost = COST_W'(1); end
            4'hD: begin kind = K_PC16;  base_cost = COST_W'(5); end
            4'hF: begin kind = K_ABS;   base_cost = COST_W'(3); end
            default: begin kind = K_ILL; base_cost = '0; end
         endcase
      end
   end

   assign indirect = pb[7] & pb[4];
   assign auto_upd = (kind == K_INC1) || (kind == K_INC2) ||
                     (kind == K_DEC1) || (kind == K_DEC2);
   assign cost     = base_cost + (indirect ? COST_W'(IND_COST) : '0);

endmodule

// File: rtl/idx_ea_calc.sv
module idx_ea_calc
   import idx_pb_pkg::*;
#(
   parameter int DW = 8,
   localparam int AW = 2 * DW
) (
   input  ea_kind_e      kind,
   input  logic [4:0]    short_ofs,
   input  logic [AW-1:0] base,
   input  logic [DW-1:0] acc_a,
   input  logic [DW-1:0] acc_b,
   input  logic [AW-1:0] ofs,
   input  logic [AW-1:0] pc_after,
   output logic [AW-1:0] ea,
   output logic [AW-1:0] wb
);

   logic [AW-1:0] sx_short, sx_a, sx_b, sx_o8, acc_d;

   assign sx_short = {{(AW-5){short_ofs[4]}}, short_ofs};
   assign sx_a     = {{(AW-DW){acc_a[DW-1]}}, acc_a};
   assign sx_b     = {{(AW-DW){acc_b[DW-1]}}, acc_b};
   assign sx_o8    = {{(AW-DW){ofs[DW-1]}}, ofs[DW-1:0]};
   assign acc_d    = {acc_a, acc_b};

   always_comb begin
      wb = base;
      unique case (kind)
         K_SHORT: ea = base + sx_short;
         K_INC1:  begin ea = base; wb = base + AW'(1); end
         K_INC2:  begin ea = base; wb = base + AW'(2); end
         K_DEC1:  begin wb = base - AW'(1); ea = wb; end
         K_DEC2:  begin wb = base - AW'(2); ea = wb; end
         K_ZERO:  ea = base;
         K_ACCB:  ea = base + sx_b;
         K_ACCA:  ea = base + sx_a;
         K_OFS8:  ea = base + sx_o8;
         K_OFS16: ea = base + ofs;
         K_ACCD:  ea = base + acc_d;
         K_PC8:   ea = pc_after + sx_o8;
         K_PC16:  ea = pc_after + ofs;
         K_ABS:   ea = ofs;
         default: ea = '0;
      endcase
   end

endmodule

// File: rtl/idx_postbyte_ea.sv
module idx_postbyte_ea
   import idx_pb_pkg::*;
#(
   parameter int DW     = 8,
   parameter int COST_W = 4,
   localparam int AW    = 2 * DW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DW-1:0]     postbyte,
   input  logic [AW-1:0]     reg_x,
   input  logic [AW-1:0]     reg_y,
   input  logic [AW-1:0]     reg_u,
   input  logic [AW-1:0]     reg_s,
   input  logic [DW-1:0]     acc_a,
   input  logic [DW-1:0]     acc_b,
   input  logic [AW-1:0]     pc_in,
   output logic              mem_req,
   output logic [AW-1:0]     mem_addr,
   input  logic              mem_valid,
   input  logic [DW-1:0]     mem_rdata,
   output logic [AW-1:0]     ea,
   output logic [AW-1:0]     pc_next,
   output logic [COST_W-1:0] cost,
   output logic              idx_we,
   output logic [1:0]        idx_sel,
   output logic [AW-1:0]     idx_wdata,
   output logic              done
);

   localparam int NUM_IDX = 4;

   generate
      if (DW != 8) begin : g_bad_dw
         $error("postbyte layout is fixed at eight bits");
      end
   endgenerate

   seq_state_e        state_q;
   logic [DW-1:0]     pb_q, a_q, b_q;
   logic [AW-1:0]     base_q, pc_q, ofs_q, addr_q, ea_q, pcn_q;
   logic [1:0]        left_q;
   logic              ind_q;
   logic [COST_W-1:0] cost_q;

   // Base register selection at start.
   logic [AW-1:0] idx_bank [NUM_IDX];
   logic [AW-1:0] sel_base;
   assign idx_bank[0] = reg_x;
   assign idx_bank[1] = reg_y;
   assign idx_bank[2] = reg_u;
   assign idx_bank[3] = reg_s;
   assign sel_base    = idx_bank[postbyte[6:5]];

   logic [1:0] nb_start, nb_q;
   assign nb_start = ofs_bytes(postbyte);
   assign nb_q     = ofs_bytes(pb_q);

   ea_kind_e          dec_kind;
   logic              dec_ind, dec_auto;
   logic [COST_W-1:0] dec_cost;

   idx_pb_decode #(.COST_W(COST_W)) u_dec (
      .pb       (pb_q),
      .kind     (dec_kind),
      .indirect (dec_ind),
      .auto_upd (dec_auto),
      .cost     (dec_cost)
   );

   logic [AW-1:0] pc_after, calc_ea, calc_wb;
   assign pc_after = pc_q + AW'(nb_q);

   idx_ea_calc #(.DW(DW)) u_calc (
      .kind      (dec_kind),
      .short_ofs (pb_q[4:0]),
      .base      (base_q),
      .acc_a     (a_q),
      .acc_b     (b_q),
      .ofs       (ofs_q),
      .pc_after  (pc_after),
      .ea        (calc_ea),
      .wb        (calc_wb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pb_q    <= '0;
         a_q     <= '0;
         b_q     <= '0;
         base_q  <= '0;
         pc_q    <= '0;
         ofs_q   <= '0;
         addr_q  <= '0;
         ea_q    <= '0;
         pcn_q   <= '0;
         left_q  <= '0;
         ind_q   <= 1'b0;
         cost_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  pb_q    <= postbyte;
                  base_q  <= sel_base;
                  a_q     <= acc_a;
                  b_q     <= acc_b;
                  pc_q    <= pc_in;
                  addr_q  <= pc_in;
                  ofs_q   <= '0;
                  ind_q   <= 1'b0;
                  left_q  <= nb_start;
                  state_q <= (nb_start != 2'd0) ? ST_REQ : ST_CALC;
               end
            end
            ST_REQ: state_q <= ST_WAIT;
            ST_WAIT: begin
               if (mem_valid) begin
                  ofs_q  <= {ofs_q[DW-1:0], mem_rdata};
                  addr_q <= addr_q + AW'(1);
                  left_q <= left_q - 2'd1;
                  if (left_q == 2'd1) begin
                     if (ind_q) begin
                        ea_q    <= {ofs_q[DW-1:0], mem_rdata};
                        state_q <= ST_FIN;
                     end else begin
                        state_q <= ST_CALC;
                     end
                  end else begin
                     state_q <= ST_REQ;
                  end
               end
            end
            ST_CALC: begin
               ea_q   <= calc_ea;
               pcn_q  <= pc_after;
               cost_q <= dec_cost;
               if (dec_ind) begin
                  addr_q  <= calc_ea;
                  left_q  <= 2'd2;
                  ind_q   <= 1'b1;
                  state_q <= ST_REQ;
               end else begin
                  state_q <= ST_FIN;
               end
            end
            ST_FIN:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req   = (state_q == ST_REQ);
   assign mem_addr  = addr_q;
   assign done      = (state_q == ST_FIN);
   assign ea        = ea_q;
   assign pc_next   = pcn_q;
   assign cost      = cost_q;
   assign idx_we    = (state_q == ST_CALC) && dec_auto;
   assign idx_sel   = pb_q[6:5];
   assign idx_wdata = calc_wb;

endmodule

// File: rtl/idx_postbyte_ea_chk.sv
module idx_postbyte_ea_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          done,
   input logic          idx_we,
   input logic          mem_req,
   input logic [7:0]    pb,
   input logic [AW-1:0] ea
);

   // R11: done lasts one cycle
   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11: a request is never repeated back to back
   a_r11_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   // R3: one write-back pulse per postbyte
   a_r3_single_wb: assert property (@(posedge clk) disable iff (!rst_n)
      idx_we |=> !idx_we);

   // R9: write-back only for the auto-update nibbles
   a_r9_wb_only_auto: assert property (@(posedge clk) disable iff (!rst_n)
      idx_we |-> (pb[7] && pb[3:2] == 2'b00));

   // R9: illegal nibbles without indirection give zero
   a_r9_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done && pb[7] && !pb[4] &&
       (pb[3:0] == 4'h7 || pb[3:0] == 4'hA || pb[3:0] == 4'hE)) |-> (ea == '0));

endmodule

bind idx_postbyte_ea idx_postbyte_ea_chk #(.AW(AW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .done    (done),
   .idx_we  (idx_we),
   .mem_req (mem_req),
   .pb      (pb_q),
   .ea      (ea)
);

// File: tb/idx_postbyte_ea_tb.sv
module idx_postbyte_ea_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  postbyte = '0;
   logic [15:0] reg_x = 16'h1000, reg_y = 16'h2345, reg_u = 16'h8000, reg_s = 16'h0001;
   logic [7:0]  acc_a = 8'h80, acc_b = 8'h7F;
   logic [15:0] pc_in = 16'h4000;
   logic        mem_req;
   logic [15:0] mem_addr;
   logic        mem_valid = 1'b0;
   logic [7:0]  mem_rdata = '0;
   logic [15:0] ea, pc_next, idx_wdata;
   logic [3:0]  cost;
   logic        idx_we, done;
   logic [1:0]  idx_sel;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   idx_postbyte_ea u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte),
      .reg_x(reg_x), .reg_y(reg_y), .reg_u(reg_u), .reg_s(reg_s),
      .acc_a(acc_a), .acc_b(acc_b), .pc_in(pc_in),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
      .mem_rdata(mem_rdata), .ea(ea), .pc_next(pc_next), .cost(cost),
      .idx_we(idx_we), .idx_sel(idx_sel), .idx_wdata(idx_wdata), .done(done)
   );

   // Byte memory contents as a function of the address.
   function automatic logic [7:0] mb(input logic [15:0] a);
      logic [7:0] t;
      t = a[7:0] * 8'd7;
      return t + a[15:8];
   endfunction

   function automatic logic [15:0] mw(input logic [15:0] a);
      return {mb(a), mb(a + 16'd1)};
   endfunction

   function automatic logic [15:0] sx8(input logic [7:0] b);
      return {{8{b[7]}}, b};
   endfunction

   // One-cycle read latency model.
   always @(posedge clk) begin
      mem_valid <= mem_req;
      mem_rdata <= mb(mem_addr);
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_case(input string tag, input logic [7:0] pb,
                           input logic [15:0] exp_ea, input logic [15:0] exp_pcn,
                           input logic [3:0] exp_cost, input int exp_lat,
                           input int exp_we, input logic [1:0] exp_sel,
                           input logic [15:0] exp_wb);
      int lat;
      int we_cnt;
      logic [15:0] wb_seen;
      logic [1:0]  sel_seen;
      wb_seen  = '0;
      sel_seen = '0;
      we_cnt   = 0;
      @(negedge clk);
      postbyte = pb;
      start    = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat   = 1;
      while (!done && lat < 60) begin
         if (idx_we) begin we_cnt++; wb_seen = idx_wdata; sel_seen = idx_sel; end
         @(negedge clk);
         lat++;
      end
      if (idx_we) we_cnt++;
      chk({tag, " R11 latency"}, lat, exp_lat);
      chk({tag, " ea"}, ea, exp_ea);
      chk({tag, " pc_next"}, pc_next, exp_pcn);
      chk({tag, " cost"}, cost, exp_cost);
      chk({tag, " R3 writeback count"}, we_cnt, exp_we);
      if (exp_we != 0) begin
         chk({tag, " R1 writeback sel"}, sel_seen, exp_sel);
         chk({tag, " writeback data"}, wb_seen, exp_wb);
      end
   endtask

   task automatic test_reset();
      chk("R12 done", done, 0);
      chk("R12 idx_we", idx_we, 0);
      chk("R12 mem_req", mem_req, 0);
      chk("R12 ea", ea, 0);
      chk("R12 pc_next", pc_next, 0);
      chk("R12 cost", cost, 0);
   endtask

   task automatic test_short();
      run_case("R2 x+5", 8'h05, 16'h1005, 16'h4000, 4'd1, 2, 0, 2'd0, 16'h0);
      run_case("R2 y-16", 8'h30, 16'h2335, 16'h4000, 4'd1, 2, 0, 2'd0, 16'h0);
      run_case("R1 s-1", 8'h7F, 16'h0000, 16'h4000, 4'd1, 2, 0, 2'd0, 16'h0);
      run_case("R1 u+0", 8'h40, 16'h8000, 16'h4000, 4'd1, 2, 0, 2'd0, 16'h0);
   endtask

   task automatic test_auto();
      run_case("R3 x++1", 8'h80, 16'h1000, 16'h4000, 4'd2, 2, 1, 2'd0, 16'h1001);
      run_case("R3 u++2", 8'hC1, 16'h8000, 16'h4000, 4'd3, 2, 1, 2'd2, 16'h8002);
      run_case("R4 --y1", 8'hA2, 16'h2344, 16'h4000, 4'd2, 2, 1, 2'd1, 16'h2344);
      run_case("R4 --s2 wrap", 8'hE3, 16'hFFFF, 16'h4000, 4'd3, 2, 1, 2'd3, 16'hFFFF);
   endtask

   task automatic test_acc();
      run_case("R5 zero", 8'h84, 16'h1000, 16'h4000, 4'd0, 2, 0, 2'd0, 16'h0);
      run_case("R5 +b", 8'h85, 16'h107F, 16'h4000, 4'd1, 2, 0, 2'd0, 16'h0);
      run_case("R5 +a neg", 8'h86, 16'h0F80, 16'h4000, 4'd1, 2, 0, 2'd0, 16'h0);
      run_case("R5 +d", 8'h8B, 16'h907F, 16'h4000, 4'd4, 2, 0, 2'd0, 16'h0);
   endtask

   task automatic test_offsets();
      pc_in = 16'h4000;
      run_case("R6 ofs8", 8'h88, 16'h1000 + sx8(mb(16'h4000)), 16'h4001, 4'd1, 4, 0, 2'd0, 16'h0);
      run_case("R6 ofs16", 8'h89, 16'h1000 + mw(16'h4000), 16'h4002, 4'd4, 6, 0, 2'd0, 16'h0);
      run_case("R7 pc8", 8'h8C, 16'h4001 + sx8(mb(16'h4000)), 16'h4001, 4'd1, 4, 0, 2'd0, 16'h0);
      run_case("R7 pc16", 8'h8D, 16'h4002 + mw(16'h4000), 16'h4002, 4'd5, 6, 0, 2'd0, 16'h0);
      run_case("R8 abs", 8'h8F, mw(16'h4000), 16'h4002, 4'd3, 6, 0, 2'd0, 16'h0);
      pc_in = 16'h40F0;
      run_case("R6 ofs8 neg", 8'h88, 16'h1000 + sx8(mb(16'h40F0)), 16'h40F1, 4'd1, 4, 0, 2'd0, 16'h0);
      run_case("R7 pc8 neg", 8'h8C, 16'h40F1 + sx8(mb(16'h40F0)), 16'h40F1, 4'd1, 4, 0, 2'd0, 16'h0);
      pc_in = 16'h4000;
   endtask

   task automatic test_illegal();
      run_case("R9 nib7", 8'h87, 16'h0000, 16'h4000, 4'd0, 2, 0, 2'd0, 16'h0);
      run_case("R9 nibA", 8'hAA, 16'h0000, 16'h4000, 4'd0, 2, 0, 2'd0, 16'h0);
      run_case("R9 nibE", 8'h8E, 16'h0000, 16'h4000, 4'd0, 2, 0, 2'd0, 16'h0);
   endtask

   task automatic test_indirect();
      run_case("R10 [x]", 8'h94, mw(16'h1000), 16'h4000, 4'd3, 6, 0, 2'd0, 16'h0);
      run_case("R10 [abs]", 8'h9F, mw(mw(16'h4000)), 16'h4002, 4'd6, 10, 0, 2'd0, 16'h0);
      run_case("R10 [--s2] wrap", 8'hF3, {mb(16'hFFFF), mb(16'h0000)}, 16'h4000, 4'd6, 6, 1, 2'd3, 16'hFFFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_short();
      test_auto();
      test_acc();
      test_offsets();
      test_illegal();
      test_indirect();
      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule